// File: doc/BRIEF.md
# Adder-Stage Issue Gate for a Shared Floating-Point Pipeline

This block decides, cycle by cycle, whether a floating-point instruction may enter an adder pipeline. Multiplies use the same adder pipeline for their last two steps. The adder has two shared resources: a mantissa-add step (A) and a rounding step (R). Add, subtract and compare instructions (the add class) use A on two consecutive cycles. They use R on two consecutive cycles, starting one cycle after their first A use. A multiply uses A once and then R once, late in its lifetime. A double multiply makes these uses one cycle later than a single multiply.

The block keeps a reservation table that is shifted forward. For each future cycle, the table holds one A bit and one R bit for multiply uses, and one A bit and one R bit for add-class uses. A multiply's A and R cycles are exclusive: nothing else may use A or R in those cycles. Add-class instructions are pipelined and may overlap each other.

When a request does not collide, `issue_ok` rises combinationally in the same cycle as the request. The request's usage pattern is then written into the table at the next clock edge. A request that is refused leaves the table unchanged, so the requester can retry in the next cycle. A stall freezes the table, and a flush empties it.

Top module: `fphz_issue_gate`

## Requirements
- R1: After a synchronous reset, `occ_a` and `occ_r` are all zero, and `issue_ok` is low while no request is present.
- R2: Bit k of `occ_a` or `occ_r` means the resource is in use k cycles from now; bit 0 means the current cycle. After an add-class grant (class code 0) into an empty table, the next cycle shows `occ_a` bits 1 and 2 set and `occ_r` bits 2 and 3 set.
- R3: After a double-multiply grant (class code 2) into an empty table, the next cycle shows only `occ_a` bit 5 and only `occ_r` bit 6 set.
- R4: After a single-multiply grant (class code 1) into an empty table, the next cycle shows only `occ_a` bit 4 and only `occ_r` bit 5 set.
- R5: After a double multiply is granted, an add-class request made 3 or 4 unstalled cycles later is refused. Requests made 1, 2, 5, 6 or 7 cycles later are granted.
- R6: After a single multiply is granted, an add-class request made 2 or 3 cycles later is refused. Requests made 1, 4, 5, 6 or 7 cycles later are granted.
- R7: Add-class requests on consecutive cycles are all granted, because add-class uses do not exclude each other.
- R8: A multiply is refused if any A or R slot it needs is already reserved, whether by a multiply or by an add-class instruction. No slot is ever held by both a multiply and an add-class instruction.
- R9: A refused request leaves the table as if no request had been made. On a cycle with no grant, stall or flush, the table only shifts down by one position.
- R10: While `stall` is high, no request is granted and the table holds its contents.
- R11: While `flush` is high, no request is granted. The next cycle shows an empty table.
- R12: Class code 3 is never granted and reserves nothing.
- R13: `issue_ok` is high only while `req_valid` is high and neither `stall` nor `flush` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An instruction asks to issue this cycle |
| req_cls | input | 2 | 0 add class, 1 single multiply, 2 double multiply, 3 unused |
| stall | input | 1 | Freeze the table and refuse issue |
| flush | input | 1 | Empty the table and refuse issue |
| issue_ok | output | 1 | The request may issue this cycle |
| occ_a | output | DEPTH | A-step use per future cycle, bit 0 is now |
| occ_r | output | DEPTH | R-step use per future cycle, bit 0 is now |

## Verification
An add request is swept across request distances 1 to 7 after each multiply width. This separates the two stated refusal windows (3–4 and 2–3) and checks that neighbouring distances are granted. The table-driven stream mixes several patterns:
- back-to-back adds, which catch any exclusion wrongly applied between add-class uses;
- refused adds followed by a retry, which show that a refusal leaves no trace;
- a multiply after a stall, which checks that a frozen cycle does not count as elapsed time;
- a multiply colliding with a multiply, an unused class code, and a request made during a flush.

A bench reference model of the four reservation vectors predicts every grant and every occupancy vector. Single grants into an empty table pin down each usage pattern bit by bit.

// File: rtl/fphz_pkg.sv
package fphz_pkg;

  typedef enum logic [1:0] {
    CLS_ADD  = 2'd0,
    CLS_MULS = 2'd1,
    CLS_MULD = 2'd2,
    CLS_NONE = 2'd3
  } op_cls_e;

endpackage

// File: rtl/fphz_pattern.sv
module fphz_pattern #(
  parameter int DEPTH      = 8,
  parameter int ADD_A_OFS  = 2,
  parameter int MULS_A_OFS = 5,
  parameter int MULD_A_OFS = 6
) (
  input  logic [1:0]       cls,
  output logic [DEPTH-1:0] pat_a,
  output logic [DEPTH-1:0] pat_r,
  output logic             is_mul,
  output logic             known
);
  import fphz_pkg::*;

  // R follows A by one cycle for every class
  localparam int ADD_R_OFS  = ADD_A_OFS + 1;
  localparam int MULS_R_OFS = MULS_A_OFS + 1;
  localparam int MULD_R_OFS = MULD_A_OFS + 1;

  op_cls_e c;
  assign c      = op_cls_e'(cls);
  assign is_mul = (c == CLS_MULS) || (c == CLS_MULD);
  assign known  = (c != CLS_NONE);

  for (genvar k = 0; k < DEPTH; k++) begin : g_bit
    always_comb begin
      unique case (c)
        CLS_ADD: begin
          pat_a[k] = (k == ADD_A_OFS) || (k == ADD_A_OFS + 1);
          pat_r[k] = (k == ADD_R_OFS) || (k == ADD_R_OFS + 1);
        end
        CLS_MULS: begin
          pat_a[k] = (k == MULS_A_OFS);
          pat_r[k] = (k == MULS_R_OFS);
        end
        CLS_MULD: begin
          pat_a[k] = (k == MULD_A_OFS);
          pat_r[k] = (k == MULD_R_OFS);
        end
        default: begin
          pat_a[k] = 1'b0;
          pat_r[k] = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/fphz_conflict.sv
module fphz_conflict #(
  parameter int DEPTH = 8
) (
  input  logic [DEPTH-1:0] pat_a,
  input  logic [DEPTH-1:0] pat_r,
  input  logic             is_mul,
  input  logic [DEPTH-1:0] add_a,
  input  logic [DEPTH-1:0] add_r,
  input  logic [DEPTH-1:0] mul_a,
  input  logic [DEPTH-1:0] mul_r,
  output logic             hit
);
  logic [DEPTH-1:0] busy_a, busy_r;

  // A multiply needs a slot nobody holds.
  // An add-class instruction only avoids multiply slots.
  always_comb begin
    busy_a = is_mul ? (add_a | mul_a) : mul_a;
    busy_r = is_mul ? (add_r | mul_r) : mul_r;
    hit    = |((pat_a & busy_a) | (pat_r & busy_r));
  end

endmodule

// File: rtl/fphz_resv_table.sv
module fphz_resv_table #(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             take_mul,
  input  logic [DEPTH-1:0] pat_a,
  input  logic [DEPTH-1:0] pat_r,
  input  logic             stall,
  input  logic             flush,
  output logic [DEPTH-1:0] add_a,
  output logic [DEPTH-1:0] add_r,
  output logic [DEPTH-1:0] mul_a,
  output logic [DEPTH-1:0] mul_r
);
  logic [DEPTH-1:0] ins_add_a, ins_add_r, ins_mul_a, ins_mul_r;

  always_comb begin
    ins_add_a = (take && !take_mul) ? pat_a : '0;
    ins_add_r = (take && !take_mul) ? pat_r : '0;
    ins_mul_a = (take &&  take_mul) ? pat_a : '0;
    ins_mul_r = (take &&  take_mul) ? pat_r : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      add_a <= '0;
      add_r <= '0;
      mul_a <= '0;
      mul_r <= '0;
    end else if (!stall) begin
      add_a <= (add_a | ins_add_a) >> 1;
      add_r <= (add_r | ins_add_r) >> 1;
      mul_a <= (mul_a | ins_mul_a) >> 1;
      mul_r <= (mul_r | ins_mul_r) >> 1;
    end
  end

  AST_LAYERS_DISJOINT: assert property (@(posedge clk) disable iff (rst)
    ((mul_a & add_a) == '0) && ((mul_r & add_r) == '0)); // R8

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> (add_a == '0) && (add_r == '0) && (mul_a == '0) && (mul_r == '0)); // R11

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (stall && !flush) |=> $stable(add_a) && $stable(add_r) && $stable(mul_a) && $stable(mul_r)); // R10

  AST_IDLE_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (!stall && !flush && !take) |=>
      (add_a == ($past(add_a) >> 1)) && (add_r == ($past(add_r) >> 1)) &&
      (mul_a == ($past(mul_a) >> 1)) && (mul_r == ($past(mul_r) >> 1))); // R9

endmodule

// File: rtl/fphz_issue_gate.sv
module fphz_issue_gate #(
  parameter int DEPTH      = 8,
  parameter int ADD_A_OFS  = 2,
  parameter int MULS_A_OFS = 5,
  parameter int MULD_A_OFS = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_cls,
  input  logic             stall,
  input  logic             flush,
  output logic             issue_ok,
  output logic [DEPTH-1:0] occ_a,
  output logic [DEPTH-1:0] occ_r
);
  // the latest R use (double multiply) must fit in the table
  localparam int LAST_USE = MULD_A_OFS + 1;

  logic [DEPTH-1:0] pat_a, pat_r;
  logic [DEPTH-1:0] add_a, add_r, mul_a, mul_r;
  logic             is_mul, known, hit;

  fphz_pattern #(
    .DEPTH(DEPTH), .ADD_A_OFS(ADD_A_OFS),
    .MULS_A_OFS(MULS_A_OFS), .MULD_A_OFS(MULD_A_OFS)
  ) u_pattern (
    .cls(req_cls), .pat_a(pat_a), .pat_r(pat_r), .is_mul(is_mul), .known(known)
  );

  fphz_conflict #(.DEPTH(DEPTH)) u_conflict (
    .pat_a(pat_a), .pat_r(pat_r), .is_mul(is_mul),
    .add_a(add_a), .add_r(add_r), .mul_a(mul_a), .mul_r(mul_r),
    .hit(hit)
  );

  assign issue_ok = !rst && req_valid && known && !stall && !flush && !hit;

  fphz_resv_table #(.DEPTH(DEPTH)) u_table (
    .clk(clk), .rst(rst), .take(issue_ok), .take_mul(is_mul),
    .pat_a(pat_a), .pat_r(pat_r), .stall(stall), .flush(flush),
    .add_a(add_a), .add_r(add_r), .mul_a(mul_a), .mul_r(mul_r)
  );

  assign occ_a = add_a | mul_a;
  assign occ_r = add_r | mul_r;

  initial begin
    AST_DEPTH_FITS: assert (DEPTH > LAST_USE); // R3
  end

  AST_GRANT_GATED: assert property (@(posedge clk) disable iff (rst)
    issue_ok |-> (req_valid && !stall && !flush)); // R13

  AST_UNUSED_CLASS: assert property (@(posedge clk) disable iff (rst)
    (req_cls == 2'd3) |-> !issue_ok); // R12

endmodule

// File: tb/fphz_issue_gate_bench.sv
module fphz_issue_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst, req_valid, stall, flush;
  logic [1:0] req_cls;
  logic issue_ok;
  logic [D-1:0] occ_a, occ_r;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fphz_issue_gate #(.DEPTH(D)) u_fphz_issue_gate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cls(req_cls),
    .stall(stall), .flush(flush), .issue_ok(issue_ok),
    .occ_a(occ_a), .occ_r(occ_r)
  );

  // reference reservation model
  logic [D-1:0] m_add_a, m_add_r, m_mul_a, m_mul_r;

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void usage(input logic [1:0] c, output logic [D-1:0] pa, output logic [D-1:0] pr);
    pa = '0; pr = '0;
    case (c)
      2'd0: begin pa[2] = 1; pa[3] = 1; pr[3] = 1; pr[4] = 1; end
      2'd1: begin pa[5] = 1; pr[6] = 1; end
      2'd2: begin pa[6] = 1; pr[7] = 1; end
      default: ;
    endcase
  endfunction

  // called at a negedge; returns at the following negedge
  task automatic step(input bit fl, input bit st, input bit v, input logic [1:0] c,
                      input int exp_ok, input string tag);
    logic [D-1:0] pa, pr;
    bit mul, conf, mok;
    flush = fl; stall = st; req_valid = v; req_cls = c;
    usage(c, pa, pr);
    mul  = (c == 2'd1) || (c == 2'd2);
    conf = mul ? |((pa & (m_add_a | m_mul_a)) | (pr & (m_add_r | m_mul_r)))
               : |((pa & m_mul_a) | (pr & m_mul_r));
    mok  = v && !fl && !st && (c != 2'd3) && !conf;
    #1;
    check(issue_ok == mok, {tag, " model grant"}, issue_ok, mok);
    if (exp_ok >= 0) check(issue_ok == exp_ok[0], {tag, " grant"}, issue_ok, exp_ok);
    @(posedge clk);
    if (fl) begin
      m_add_a = '0; m_add_r = '0; m_mul_a = '0; m_mul_r = '0;
    end else if (!st) begin
      if (mok && mul) begin m_mul_a |= pa; m_mul_r |= pr; end
      if (mok && !mul) begin m_add_a |= pa; m_add_r |= pr; end
      m_add_a >>= 1; m_add_r >>= 1; m_mul_a >>= 1; m_mul_r >>= 1;
    end
    @(negedge clk);
    check(occ_a == (m_add_a | m_mul_a), {tag, " occ_a"}, occ_a, m_add_a | m_mul_a);
    check(occ_r == (m_add_r | m_mul_r), {tag, " occ_r"}, occ_r, m_add_r | m_mul_r);
  endtask

  // {flush, stall, valid, cls[1:0], exp_ok}
  localparam logic [5:0] STIM [20] = '{
    6'b001_00_1, // R7 add
    6'b001_00_1, // R7 add
    6'b001_00_1, // R7 add
    6'b000_00_0,
    6'b000_00_0,
    6'b000_00_0,
    6'b000_00_0,
    6'b001_01_1, // single multiply
    6'b000_00_0,
    6'b001_00_0, // R6 R9 distance 2 refused
    6'b001_00_0, // R6 R9 distance 3 refused
    6'b001_00_1, // R9 retry granted
    6'b001_01_1, // single multiply
    6'b011_00_0, // R10 stalled
    6'b001_10_1, // double multiply after stall
    6'b001_01_0, // R8 multiply collides with multiply
    6'b001_11_0, // R12 unused class
    6'b101_00_0, // R11 flush refuses
    6'b001_01_1, // clean after flush
    6'b000_00_0  // R13 no request
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_add_a = '0; m_add_r = '0; m_mul_a = '0; m_mul_r = '0;
    rst = 1; req_valid = 0; req_cls = 0; stall = 0; flush = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    // R1 reset state
    check(occ_a == '0, "R1 occ_a", occ_a, 0);
    check(occ_r == '0, "R1 occ_r", occ_r, 0);
    check(issue_ok == 1'b0, "R1 issue_ok", issue_ok, 0);
    @(negedge clk);

    foreach (STIM[i]) begin
      step(STIM[i][5], STIM[i][4], STIM[i][3], STIM[i][2:1], STIM[i][0], $sformatf("row%0d", i));
    end

    // R2 add-class usage pattern
    step(1, 0, 0, 2'd0, -1, "R2 flush");
    step(0, 0, 1, 2'd0, 1, "R2 add");
    check(occ_a == 8'b0000_0110, "R2 occ_a", occ_a, 8'b0000_0110);
    check(occ_r == 8'b0000_1100, "R2 occ_r", occ_r, 8'b0000_1100);

    // R3 double multiply usage pattern
    step(1, 0, 0, 2'd0, -1, "R3 flush");
    step(0, 0, 1, 2'd2, 1, "R3 muld");
    check(occ_a == 8'b0010_0000, "R3 occ_a", occ_a, 8'b0010_0000);
    check(occ_r == 8'b0100_0000, "R3 occ_r", occ_r, 8'b0100_0000);

    // R4 single multiply usage pattern
    step(1, 0, 0, 2'd0, -1, "R4 flush");
    step(0, 0, 1, 2'd1, 1, "R4 muls");
    check(occ_a == 8'b0001_0000, "R4 occ_a", occ_a, 8'b0001_0000);
    check(occ_r == 8'b0010_0000, "R4 occ_r", occ_r, 8'b0010_0000);

    // R9 refusal leaves only the shifted multiply reservation
    step(1, 0, 0, 2'd0, -1, "R9 flush");
    step(0, 0, 1, 2'd1, 1, "R9 muls");
    step(0, 0, 0, 2'd0, 0, "R9 idle");
    step(0, 0, 1, 2'd0, 0, "R9 refused add");
    check(occ_a == 8'b0000_0100, "R9 occ_a", occ_a, 8'b0000_0100);
    check(occ_r == 8'b0000_1000, "R9 occ_r", occ_r, 8'b0000_1000);

    // R5 sweep after double multiply
    for (int d = 1; d <= 7; d++) begin
      step(1, 0, 0, 2'd0, -1, "R5 flush");
      step(0, 0, 1, 2'd2, 1, "R5 muld");
      for (int k = 1; k < d; k++) step(0, 0, 0, 2'd0, 0, "R5 gap");
      step(0, 0, 1, 2'd0, (d == 3 || d == 4) ? 0 : 1, $sformatf("R5 dist%0d", d));
    end

    // R6 sweep after single multiply
    for (int d = 1; d <= 7; d++) begin
      step(1, 0, 0, 2'd0, -1, "R6 flush");
      step(0, 0, 1, 2'd1, 1, "R6 muls");
      for (int k = 1; k < d; k++) step(0, 0, 0, 2'd0, 0, "R6 gap");
      step(0, 0, 1, 2'd0, (d == 2 || d == 3) ? 0 : 1, $sformatf("R6 dist%0d", d));
    end

    // R11 flush empties a busy table
    step(0, 0, 1, 2'd2, -1, "R11 fill");
    step(1, 0, 1, 2'd0, 0, "R11 flush");
    check(occ_a == '0 && occ_r == '0, "R11 empty", occ_a | occ_r, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule